// File: doc/BRIEF.md
# Data Memory Stage with Ready Wait

This block is the data-memory stage of a pipelined accumulator-style core. The ALU stage starts a memory cycle by loading the stage's address register. In the same cycle it supplies the access kind (read or write), the width (byte or 16-bit word), the issuing reservation station and the forwarded second operand. The stage then drives the read/write data channel and holds every bus output steady until the external ready input is sampled high. A slow memory or an external controller can therefore stretch any access for as many cycles as it needs.

When a load completes, the returned data is written into the temporary register owned by the issuing reservation station, never into the register file. A byte load is zero-extended to 16 bits. A store drives the forwarded operand on the write data lanes. For a byte store the operand's low byte goes on the low lane and a byte-width flag is raised beside the write strobe. A word access at an odd address is not treated as a fault. The stage waits on ready like any other access while outside logic completes it.

A busy output tells the scheduler that the data channel is taken, so no second memory micro-op can start. The controller has two states. IDLE takes the "launch" transition to ACCESS when a start request arrives. ACCESS takes the "hold" transition to itself while ready is low, and the "finish" transition back to IDLE in the cycle ready is high.

Top module: `mem_stage`

## Requirements
- R1: After reset, busy, done, both strobes and the byte flag are low, the address output is 0, and every station's temporary register is 0.
- R2: A start request while idle makes busy high one cycle later. In that cycle the address, width and station given with the request are presented: the read strobe is high for a read and the write strobe for a write. busy is high exactly when one strobe is high.
- R3: While busy and ready is low, the address, both strobes, the byte flag and the write data do not change.
- R4: When ready is sampled high while busy, the next cycle has busy and both strobes low and done high for exactly one cycle.
- R5: A completed load writes only the temporary register of the issuing station; the other station's register keeps its value. Station code 0 is station A (tmp_bank_o bits 15:0); code 1 is station B (bits 31:16).
- R6: A word load (start_word_i = 1) stores all 16 bits of mem_rdata_i. A byte load (start_word_i = 0) stores mem_rdata_i[7:0] with bits 15:8 cleared.
- R7: A store raises the write strobe and never the read strobe, and leaves every temporary register unchanged. Its write data is the forwarded operand for a word store. For a byte store it is the operand's low byte on bits 7:0 with bits 15:8 zero, and mem_byte_o is high.
- R8: A start request while busy is ignored: the address in progress stays on the bus and no second access follows the current one.
- R9: A word access at an odd address presents that address unchanged, raises no error, and completes on ready like an aligned access.
- R10: Ready pulses while idle have no effect: done stays low and the temporary registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | ALU stage loads the address register and starts a cycle |
| start_addr_i | input | ADDR_W | Access address |
| start_wr_i | input | 1 | 1 = store, 0 = load |
| start_word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| start_stn_i | input | STN_W | Issuing reservation station (0 = A, 1 = B) |
| store_opnd_i | input | DATA_W | Forwarded second ALU operand, used as store data |
| busy_o | output | 1 | Data channel occupied |
| done_o | output | 1 | One-cycle pulse after an access completes |
| mem_addr_o | output | ADDR_W | Data bus address |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_byte_o | output | 1 | Byte-width access indication |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, sampled with ready |
| mem_rdy_i | input | 1 | External ready; the access completes in a cycle where it is high |
| tmp_bank_o | output | NUM_STN*DATA_W | Per-station temporary registers, station 0 in the low bits |

## Verification
The checker module watches the rules that hold on every cycle. A launch from idle must raise busy, and busy must agree with exactly one strobe. The bus must hold steady while ready is low. Completion must be followed by a single done pulse. Starts while busy must not move the address, and the temporary registers may change only after a completion.

Only the bench's directed scenarios can show data correctness. These cover which station's register receives a load, zero-extension of byte loads, byte-lane placement of store data, odd-address word accesses, and the absence of any extra access after an ignored start.

// File: rtl/memstg_pkg.sv
package memstg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } memstg_state_e;

    typedef enum logic [0:0] {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } memstg_size_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/memstg_ctrl.sv
module memstg_ctrl
    import memstg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rdy_i,
    output logic busy_o,
    output logic latch_o,
    output logic complete_o,
    output logic done_o
);

    memstg_state_e state_q;
    memstg_state_e state_d;
    logic          done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= complete_o;
        end
    end

    // next state and strobes
    always_comb begin
        state_d    = state_q;
        latch_o    = 1'b0;
        complete_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    latch_o = 1'b1;          // launch
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (rdy_i) begin
                    complete_o = 1'b1;       // finish
                    state_d    = ST_IDLE;
                end                          // else hold
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy_o = (state_q == ST_ACCESS);
    assign done_o = done_q;

endmodule

// File: rtl/memstg_mar.sv
module memstg_mar
    import memstg_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STN_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  memstg_size_e      size_i,
    input  logic [STN_W-1:0]  stn_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              mem_byte_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              wr_o,
    output memstg_size_e      size_o,
    output logic [STN_W-1:0]  stn_o
);

    localparam int unsigned HI_W = DATA_W - LANE_W;

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    memstg_size_e      size_q;
    logic [STN_W-1:0]  stn_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] wdata_d;

    // place store data on the lanes at capture time
    always_comb begin
        if (size_i == SZ_WORD) begin
            wdata_d = opnd_i;
        end else begin
            wdata_d = {{HI_W{1'b0}}, opnd_i[LANE_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            size_q  <= SZ_BYTE;
            stn_q   <= '0;
            wdata_q <= '0;
        end else if (latch_i) begin
            addr_q  <= addr_i;
            wr_q    <= wr_i;
            size_q  <= size_i;
            stn_q   <= stn_i;
            wdata_q <= wdata_d;
        end
    end

    assign mem_addr_o  = addr_q;
    assign mem_we_o    = busy_i && wr_q;
    assign mem_re_o    = busy_i && !wr_q;
    assign mem_byte_o  = busy_i && (size_q == SZ_BYTE);
    assign mem_wdata_o = wdata_q;
    assign wr_o        = wr_q;
    assign size_o      = size_q;
    assign stn_o       = stn_q;

endmodule

// File: rtl/memstg_tmpbank.sv
module memstg_tmpbank
    import memstg_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_STN = 2,
    parameter int unsigned STN_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      complete_i,
    input  logic                      wr_i,
    input  memstg_size_e              size_i,
    input  logic [STN_W-1:0]          stn_i,
    input  logic [DATA_W-1:0]         rdata_i,
    output logic [NUM_STN*DATA_W-1:0] tmp_bank_o
);

    localparam int unsigned HI_W = DATA_W - LANE_W;

    logic [DATA_W-1:0] load_val;
    logic              load_en;

    always_comb begin
        if (size_i == SZ_WORD) begin
            load_val = rdata_i;
        end else begin
            load_val = {{HI_W{1'b0}}, rdata_i[LANE_W-1:0]};
        end
    end

    assign load_en = complete_i && !wr_i;

    for (genvar g = 0; g < NUM_STN; g++) begin : g_stn
        logic [DATA_W-1:0] tmp_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmp_q <= '0;
            end else if (load_en && (stn_i == STN_W'(g))) begin
                tmp_q <= load_val;
            end
        end
        assign tmp_bank_o[g*DATA_W +: DATA_W] = tmp_q;
    end

endmodule

// File: rtl/mem_stage.sv
module mem_stage
    import memstg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_STN = 2,
    localparam int unsigned STN_W  = (NUM_STN > 1) ? $clog2(NUM_STN) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         start_addr_i,
    input  logic                      start_wr_i,
    input  logic                      start_word_i,
    input  logic [STN_W-1:0]          start_stn_i,
    input  logic [DATA_W-1:0]         store_opnd_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic                      mem_re_o,
    output logic                      mem_we_o,
    output logic                      mem_byte_o,
    output logic [DATA_W-1:0]         mem_wdata_o,
    input  logic [DATA_W-1:0]         mem_rdata_i,
    input  logic                      mem_rdy_i,
    output logic [NUM_STN*DATA_W-1:0] tmp_bank_o
);

    logic             latch;
    logic             complete;
    logic             wr_q;
    memstg_size_e     size_q;
    logic [STN_W-1:0] stn_q;

    memstg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rdy_i      (mem_rdy_i),
        .busy_o     (busy_o),
        .latch_o    (latch),
        .complete_o (complete),
        .done_o     (done_o)
    );

    memstg_mar #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STN_W  (STN_W)
    ) u_mar (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_i     (latch),
        .busy_i      (busy_o),
        .addr_i      (start_addr_i),
        .wr_i        (start_wr_i),
        .size_i      (memstg_size_e'(start_word_i)),
        .stn_i       (start_stn_i),
        .opnd_i      (store_opnd_i),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_byte_o  (mem_byte_o),
        .mem_wdata_o (mem_wdata_o),
        .wr_o        (wr_q),
        .size_o      (size_q),
        .stn_o       (stn_q)
    );

    memstg_tmpbank #(
        .DATA_W  (DATA_W),
        .NUM_STN (NUM_STN),
        .STN_W   (STN_W)
    ) u_tmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .complete_i (complete),
        .wr_i       (wr_q),
        .size_i     (size_q),
        .stn_i      (stn_q),
        .rdata_i    (mem_rdata_i),
        .tmp_bank_o (tmp_bank_o)
    );

endmodule

// File: rtl/mem_stage_chk.sv
module mem_stage_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_STN = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      busy_o,
    input logic                      done_o,
    input logic [ADDR_W-1:0]         mem_addr_o,
    input logic                      mem_re_o,
    input logic                      mem_we_o,
    input logic                      mem_byte_o,
    input logic [DATA_W-1:0]         mem_wdata_o,
    input logic                      mem_rdy_i,
    input logic [NUM_STN*DATA_W-1:0] tmp_bank_o
);

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R2

    AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (mem_we_o || mem_re_o)); // R2

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_rdy_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_re_o)
                                    && $stable(mem_byte_o) && $stable(mem_wdata_o))); // R3

    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mem_rdy_i) |=> (!busy_o && done_o)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_re_o})); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_rdy_i && start_i) |=> (busy_o && $stable(mem_addr_o))); // R8

    AST_TMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && mem_rdy_i) |=> $stable(tmp_bank_o)); // R10

endmodule

bind mem_stage mem_stage_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_STN (NUM_STN)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_byte_o  (mem_byte_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdy_i   (mem_rdy_i),
    .tmp_bank_o  (tmp_bank_o)
);

// File: tb/mem_stage_tb_top.sv
module mem_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [15:0] start_addr_i;
    logic        start_wr_i;
    logic        start_word_i;
    logic [0:0]  start_stn_i;
    logic [15:0] store_opnd_i;
    logic        busy_o;
    logic        done_o;
    logic [15:0] mem_addr_o;
    logic        mem_re_o;
    logic        mem_we_o;
    logic        mem_byte_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i;
    logic        mem_rdy_i;
    logic [31:0] tmp_bank_o;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_tmp [2];

    always #2.5 clk = ~clk;

    mem_stage dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .start_wr_i   (start_wr_i),
        .start_word_i (start_word_i),
        .start_stn_i  (start_stn_i),
        .store_opnd_i (store_opnd_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .mem_addr_o   (mem_addr_o),
        .mem_re_o     (mem_re_o),
        .mem_we_o     (mem_we_o),
        .mem_byte_o   (mem_byte_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rdy_i    (mem_rdy_i),
        .tmp_bank_o   (tmp_bank_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_tmp(input string req);
        chk(req, "tmp A", {16'h0, tmp_bank_o[15:0]}, {16'h0, exp_tmp[0]});
        chk(req, "tmp B", {16'h0, tmp_bank_o[31:16]}, {16'h0, exp_tmp[1]});
    endtask

    // one complete access; intrude drives a second start while waiting
    task automatic run_access(input logic [15:0] addr, input logic wr, input logic word,
                              input logic stn, input logic [15:0] opnd, input logic [15:0] rdata,
                              input int waits, input logic intrude);
        logic [15:0] exp_wd;
        exp_wd = word ? opnd : {8'h00, opnd[7:0]};
        @(negedge clk);
        start_i = 1'b1; start_addr_i = addr; start_wr_i = wr;
        start_word_i = word; start_stn_i = stn; store_opnd_i = opnd;
        @(negedge clk);
        start_i = 1'b0; start_addr_i = 16'h0; store_opnd_i = 16'h0;
        chk("R2", "busy after launch", {31'h0, busy_o}, 32'h1);
        chk("R2", "address", {16'h0, mem_addr_o}, {16'h0, addr});
        chk("R2", "read strobe", {31'h0, mem_re_o}, {31'h0, !wr});
        chk("R7", "write strobe", {31'h0, mem_we_o}, {31'h0, wr});
        chk("R7", "byte flag", {31'h0, mem_byte_o}, {31'h0, !word});
        if (wr) chk("R7", "write data", {16'h0, mem_wdata_o}, {16'h0, exp_wd});
        for (int i = 0; i < waits; i++) begin
            if (intrude && i == 0) begin
                start_i = 1'b1; start_addr_i = 16'h7777; start_wr_i = !wr;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk("R3", "busy while waiting", {31'h0, busy_o}, 32'h1);
            chk(intrude ? "R8" : "R3", "address held", {16'h0, mem_addr_o}, {16'h0, addr});
            chk("R3", "write strobe held", {31'h0, mem_we_o}, {31'h0, wr});
            if (wr) chk("R3", "write data held", {16'h0, mem_wdata_o}, {16'h0, exp_wd});
        end
        mem_rdy_i = 1'b1; mem_rdata_i = rdata;
        @(negedge clk);
        mem_rdy_i = 1'b0; mem_rdata_i = 16'hDEAD;
        if (!wr) exp_tmp[stn] = word ? rdata : {8'h00, rdata[7:0]};
        chk("R4", "busy after finish", {31'h0, busy_o}, 32'h0);
        chk("R4", "done pulse", {31'h0, done_o}, 32'h1);
        chk("R4", "strobes idle", {30'h0, mem_we_o, mem_re_o}, 32'h0);
        chk(wr ? "R7" : "R5", "temps after access", tmp_bank_o, {exp_tmp[1], exp_tmp[0]});
        @(negedge clk);
        chk("R4", "done single cycle", {31'h0, done_o}, 32'h0);
        chk(intrude ? "R8" : "R4", "no follow-on access", {31'h0, busy_o}, 32'h0);
        @(negedge clk);
        chk(intrude ? "R8" : "R4", "still idle", {30'h0, mem_we_o, mem_re_o}, 32'h0);
    endtask

    task automatic t_reset;
        chk("R1", "busy", {31'h0, busy_o}, 32'h0);
        chk("R1", "done", {31'h0, done_o}, 32'h0);
        chk("R1", "strobes+byte", {29'h0, mem_we_o, mem_re_o, mem_byte_o}, 32'h0);
        chk("R1", "address", {16'h0, mem_addr_o}, 32'h0);
        chk_tmp("R1");
    endtask

    task automatic t_word_load;   // R5 R6 word load to station A
        run_access(16'h1234, 1'b0, 1'b1, 1'b0, 16'h0, 16'hBEEF, 3, 1'b0);
        chk_tmp("R6");
    endtask

    task automatic t_byte_load;   // R6 byte load to station B, zero-extended
        run_access(16'h0041, 1'b0, 1'b0, 1'b1, 16'h0, 16'hA5C3, 0, 1'b0);
        chk("R6", "zero-extended byte", {16'h0, tmp_bank_o[31:16]}, 32'h0000_00C3);
        chk("R5", "station A untouched", {16'h0, tmp_bank_o[15:0]}, 32'h0000_BEEF);
    endtask

    task automatic t_stores;      // R7 word and byte stores
        run_access(16'h2000, 1'b1, 1'b1, 1'b0, 16'h1357, 16'hFFFF, 2, 1'b0);
        run_access(16'h2003, 1'b1, 1'b0, 1'b1, 16'h9ABC, 16'hFFFF, 1, 1'b0);
        chk_tmp("R7");
    endtask

    task automatic t_busy_start;  // R8
        run_access(16'h0550, 1'b0, 1'b1, 1'b1, 16'h0, 16'h6161, 3, 1'b1);
    endtask

    task automatic t_odd_word;    // R9
        run_access(16'h3001, 1'b0, 1'b1, 1'b0, 16'h0, 16'h4242, 4, 1'b0);
        chk("R9", "odd word load", {16'h0, tmp_bank_o[15:0]}, 32'h0000_4242);
    endtask

    task automatic t_idle_rdy;    // R10
        @(negedge clk);
        mem_rdy_i = 1'b1; mem_rdata_i = 16'h5A5A;
        repeat (3) begin
            @(negedge clk);
            chk("R10", "no done while idle", {31'h0, done_o}, 32'h0);
            chk("R10", "no busy while idle", {31'h0, busy_o}, 32'h0);
        end
        mem_rdy_i = 1'b0;
        @(negedge clk);
        chk_tmp("R10");
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_addr_i = 16'h0; start_wr_i = 1'b0;
        start_word_i = 1'b0; start_stn_i = 1'b0; store_opnd_i = 16'h0;
        mem_rdata_i = 16'h0; mem_rdy_i = 1'b0;
        exp_tmp[0] = 16'h0; exp_tmp[1] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_load();
        t_byte_load();
        t_stores();
        t_busy_start();
        t_odd_word();
        t_idle_rdy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R4 watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule